// File: doc/BRIEF.md
# Task-Driven Compare Timer

A counting timer that software drives through one-shot command writes ("tasks") and observes through four sticky compare flags ("events"). A word-addressed register bus holds the commands, the configuration and the compare values. The counter has a run-time selectable width of 8, 16, 24 or 32 bits and wraps to zero past its maximum. In timer mode it advances on a divided version of the base clock. The divider is a power of two chosen by a prescaler register. In counter mode it advances once for each count command instead.

Each of the four compare channels watches the counter and raises its flag on the advance that brings the counter onto its compare value. Only the low bits of the active width take part in the comparison. A flag stays raised until software writes zero to it. Per-channel shortcut bits can make a match clear the counter, stop it, or both, so the block can act as a periodic or one-shot timer without software help. The four flags are also driven out as level outputs for the surrounding logic.

Top module: `evt_timer`

## Requirements
- R1: A bus write with data bit 0 set to word address 0 starts the counter and to address 1 stops it. A stopped counter keeps its value. A start does not clear the counter.
- R2: A bus write with data bit 0 set to address 3 sets the counter to 0. It raises no compare flag. The counter value reads back at address 16.
- R3: In timer mode, with prescaler value p written at address 6, the counter advances once every 2^p base clock cycles, counted from the start command. p = 0 advances it on every cycle. Written values above PRESC_MAX read back and act as PRESC_MAX.
- R4: The width register at address 5 selects the counter width: 0 gives 16 bits, 1 gives 8, 2 gives 24 and 3 gives 32. The counter wraps to 0 after the largest value of that width. Compares use only that many low bits.
- R5: Compare value i (address 8+i) raises flag i on the advance that makes the counter equal to it. A compare value below the current count fires only after the counter wraps and reaches it.
- R6: Flag i (read at address 12+i and on output bit i) stays 1 until a write of 0 to address 12+i. A write of any nonzero value to that address leaves it unchanged.
- R7: With bit i of the shortcut register (address 7) set, a match on channel i loads the counter with 0 instead of the compare value, so the count repeats with a period equal to the compare value.
- R8: With bit 4+i of the shortcut register set, a match on channel i stops the counter, which stays at the compare value.
- R9: With the mode register (address 4) at 1, the running counter advances once for each write with bit 0 set to address 2 and ignores the clock. While stopped, those writes have no effect.
- R10: A clear command and an advance in the same cycle leave the counter at 0.
- R11: After reset the counter, all flags, the compare values, the mode, the prescaler and the width register read 0, and the counter is stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock; one cycle is the undivided tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cmp_evt | output | NUM_CMP | Sticky compare flags |

## Verification
The bench builds the block with its defaults: four channels, a 32-bit counter and a prescaler limit of 9. This lets every width code be exercised, including a full 16-bit wrap in about 65k cycles. It also lets prescaler clamping be checked by writing 15. Random runs use small prescaler values and mostly the 8-bit width, so that wrap-around and compare values below the current count come up often within a few hundred cycles.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

   typedef enum logic [1:0] {
      WID_16 = 2'd0,
      WID_8  = 2'd1,
      WID_24 = 2'd2,
      WID_32 = 2'd3
   } width_e;

   localparam int A_GO     = 0;
   localparam int A_HALT   = 1;
   localparam int A_BUMP   = 2;
   localparam int A_ZERO   = 3;
   localparam int A_MODE   = 4;
   localparam int A_WIDTH  = 5;
   localparam int A_PRESC  = 6;
   localparam int A_SHORTS = 7;
   localparam int A_CC0    = 8;

   function automatic logic [31:0] width_mask(width_e w);
      case (w)
         WID_8:   return 32'h0000_00FF;
         WID_24:  return 32'h00FF_FFFF;
         WID_32:  return 32'hFFFF_FFFF;
         default: return 32'h0000_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/evt_timer_presc.sv
module evt_timer_presc #(
   parameter int PRESC_MAX = 9,
   localparam int PW    = (PRESC_MAX > 0) ? $clog2(PRESC_MAX + 1) : 1,
   localparam int DIV_W = (PRESC_MAX > 0) ? PRESC_MAX : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          restart,
   input  logic [PW-1:0] presc,
   output logic          tick
);

   generate
      if (PRESC_MAX == 0) begin : g_nodiv
         assign tick = run;
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ restart ^ (^presc);
      end else begin : g_div
         logic [DIV_W-1:0] div_q;
         logic [DIV_W-1:0] sel;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               div_q <= '0;
            else if (restart)
               div_q <= '0;
            else if (run)
               div_q <= div_q + DIV_W'(1);
         end

         // low p bits all ones on every 2^p-th cycle
         assign sel  = DIV_W'((64'd1 << presc) - 64'd1);
         assign tick = run && ((div_q & sel) == sel);
      end
   endgenerate

endmodule

// File: rtl/evt_timer_count.sv
module evt_timer_count #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             zero,
   input  logic [CNT_W-1:0] wmask,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_inc
);

   assign cnt_inc = (cnt_q + CNT_W'(1)) & wmask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (zero)
         cnt_q <= '0;
      else if (step)
         cnt_q <= cnt_inc;
   end

endmodule

// File: rtl/evt_timer_cmp.sv
module evt_timer_cmp #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [CNT_W-1:0] cnt_inc,
   input  logic [CNT_W-1:0] cc,
   input  logic [CNT_W-1:0] wmask,
   input  logic             evt_clr,
   output logic             hit,
   output logic             evt_q
);

   assign hit = step && (((cnt_inc ^ cc) & wmask) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         evt_q <= 1'b0;
      else if (hit)
         evt_q <= 1'b1;
      else if (evt_clr)
         evt_q <= 1'b0;
   end

endmodule

// File: rtl/evt_timer.sv
module evt_timer
   import evt_timer_pkg::*;
#(
   parameter int NUM_CMP   = 4,
   parameter int CNT_W     = 32,
   parameter int PRESC_MAX = 9,
   parameter int ADDR_W    = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic [NUM_CMP-1:0] cmp_evt
);

   localparam int PW       = (PRESC_MAX > 0) ? $clog2(PRESC_MAX + 1) : 1;
   localparam int EVT_BASE = A_CC0 + NUM_CMP;
   localparam int CNT_ADDR = EVT_BASE + NUM_CMP;
   localparam int SH_W     = 2 * NUM_CMP;

   generate
      if (CNT_W < 8 || CNT_W > 32) begin : g_bad_cnt
         $error("evt_timer: CNT_W must lie in 8..32");
      end
      if (NUM_CMP < 1 || SH_W > 32) begin : g_bad_cmp
         $error("evt_timer: NUM_CMP must lie in 1..16");
      end
      if ((1 << ADDR_W) <= CNT_ADDR) begin : g_bad_addr
         $error("evt_timer: ADDR_W too small for the register map");
      end
      if (PRESC_MAX < 0 || PRESC_MAX > 31) begin : g_bad_presc
         $error("evt_timer: PRESC_MAX must lie in 0..31");
      end
   endgenerate

   // command decode
   function automatic logic cmd(input int a);
      return bus_wr && (bus_addr == ADDR_W'(a)) && bus_wdata[0];
   endfunction

   function automatic logic cfg(input int a);
      return bus_wr && (bus_addr == ADDR_W'(a));
   endfunction

   logic go_t, halt_t, bump_t, zero_t;
   assign go_t   = cmd(A_GO);
   assign halt_t = cmd(A_HALT);
   assign bump_t = cmd(A_BUMP);
   assign zero_t = cmd(A_ZERO);

   // configuration state
   logic             run_q;
   logic             mode_q;
   width_e           wid_q;
   logic [PW-1:0]    presc_q;
   logic [SH_W-1:0]  shorts_q;
   logic [CNT_W-1:0] cc_q [NUM_CMP];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= 1'b0;
         wid_q    <= WID_16;
         presc_q  <= '0;
         shorts_q <= '0;
      end else begin
         if (cfg(A_MODE))   mode_q   <= bus_wdata[0];
         if (cfg(A_WIDTH))  wid_q    <= width_e'(bus_wdata[1:0]);
         if (cfg(A_SHORTS)) shorts_q <= bus_wdata[SH_W-1:0];
         if (cfg(A_PRESC))
            presc_q <= (bus_wdata > 32'(PRESC_MAX)) ? PW'(PRESC_MAX)
                                                    : bus_wdata[PW-1:0];
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CMP; gi++) begin : g_ccreg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cc_q[gi] <= '0;
            else if (cfg(A_CC0 + gi))
               cc_q[gi] <= bus_wdata[CNT_W-1:0];
         end
      end
   endgenerate

   // active width mask
   logic [31:0]      wmask32;
   logic [CNT_W-1:0] wmask;
   assign wmask32 = width_mask(wid_q);
   assign wmask   = wmask32[CNT_W-1:0];

   // advance source
   logic tick, step;
   evt_timer_presc #(.PRESC_MAX(PRESC_MAX)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q && !mode_q),
      .restart (go_t),
      .presc   (presc_q),
      .tick    (tick)
   );
   assign step = mode_q ? (run_q && bump_t) : tick;

   // counter
   logic [CNT_W-1:0]   cnt_q, cnt_inc;
   logic [NUM_CMP-1:0] hits;
   logic               short_zero, short_halt;

   assign short_zero = |(hits & shorts_q[NUM_CMP-1:0]);
   assign short_halt = |(hits & shorts_q[SH_W-1:NUM_CMP]);

   evt_timer_count #(.CNT_W(CNT_W)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .zero    (zero_t || short_zero),
      .wmask   (wmask),
      .cnt_q   (cnt_q),
      .cnt_inc (cnt_inc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= 1'b0;
      else if (halt_t || short_halt)
         run_q <= 1'b0;
      else if (go_t)
         run_q <= 1'b1;
   end

   // compare channels
   generate
      for (gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
         evt_timer_cmp #(.CNT_W(CNT_W)) u_cmp (
            .clk     (clk),
            .rst_n   (rst_n),
            .step    (step),
            .cnt_inc (cnt_inc),
            .cc      (cc_q[gi]),
            .wmask   (wmask),
            .evt_clr (cfg(EVT_BASE + gi) && (bus_wdata == 32'd0)),
            .hit     (hits[gi]),
            .evt_q   (cmp_evt[gi])
         );
      end
   endgenerate

   // read mux
   always_comb begin
      bus_rdata = 32'd0;
      if (bus_addr == ADDR_W'(A_MODE))   bus_rdata = 32'(mode_q);
      if (bus_addr == ADDR_W'(A_WIDTH))  bus_rdata = 32'(wid_q);
      if (bus_addr == ADDR_W'(A_PRESC))  bus_rdata = 32'(presc_q);
      if (bus_addr == ADDR_W'(A_SHORTS)) bus_rdata = 32'(shorts_q);
      if (bus_addr == ADDR_W'(CNT_ADDR)) bus_rdata = 32'(cnt_q & wmask);
      for (int i = 0; i < NUM_CMP; i++) begin
         if (bus_addr == ADDR_W'(A_CC0 + i))    bus_rdata = 32'(cc_q[i]);
         if (bus_addr == ADDR_W'(EVT_BASE + i)) bus_rdata = 32'(cmp_evt[i]);
      end
   end

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
   import evt_timer_pkg::*;
#(
   parameter int NUM_CMP = 4,
   parameter int CNT_W   = 32,
   parameter int ADDR_W  = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [31:0]        bus_wdata,
   input logic               run_q,
   input logic               step,
   input logic [CNT_W-1:0]   cnt_q,
   input logic [CNT_W-1:0]   wmask,
   input logic [NUM_CMP-1:0] evt
);

   localparam int EVT_BASE = A_CC0 + NUM_CMP;

   logic zero_cmd, halt_cmd;
   assign zero_cmd = bus_wr && (bus_addr == ADDR_W'(A_ZERO)) && bus_wdata[0];
   assign halt_cmd = bus_wr && (bus_addr == ADDR_W'(A_HALT)) && bus_wdata[0];

   // R10: clear command always wins over an advance
   p_zero_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      zero_cmd |=> (cnt_q == '0));

   // R1: stop command halts the counter
   p_halt_r1: assert property (@(posedge clk) disable iff (!rst_n)
      halt_cmd |=> !run_q);

   // R1: a stopped counter holds unless cleared
   p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !zero_cmd) |=> $stable(cnt_q));

   // R4: an advance moves by one within the width, or lands on 0
   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !zero_cmd) |=>
         ((cnt_q == (($past(cnt_q) + CNT_W'(1)) & $past(wmask))) || (cnt_q == '0)));

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CMP; gi++) begin : g_evt
         // R6: a flag only drops on a write to its own address
         p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[gi] && !(bus_wr && bus_addr == ADDR_W'(EVT_BASE + gi))) |=> evt[gi]);

         // R5: a flag only rises on an advance
         p_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(evt[gi]) |-> $past(step));
      end
   endgenerate

endmodule

bind evt_timer evt_timer_chk #(
   .NUM_CMP (NUM_CMP),
   .CNT_W   (CNT_W),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .run_q     (run_q),
   .step      (step),
   .cnt_q     (cnt_q),
   .wmask     (wmask),
   .evt       (cmp_evt)
);

// File: tb/sim_evt_timer.sv
`timescale 1ns/1ps
module sim_evt_timer;

   localparam int NUM_CMP = 4;
   localparam int ADDR_W  = 5;
   localparam int A_GO = 0, A_HALT = 1, A_BUMP = 2, A_ZERO = 3;
   localparam int A_MODE = 4, A_WIDTH = 5, A_PRESC = 6, A_SHORTS = 7;
   localparam int A_CC = 8, A_EVT = 12, A_CNT = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NUM_CMP-1:0] cmp_evt;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   evt_timer u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cmp_evt   (cmp_evt)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // all tasks enter and leave shortly after a falling edge
   task automatic wr(input int a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
      @(negedge clk);
      #1;
      bus_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic rd(input int a, output logic [31:0] v);
      bus_addr = ADDR_W'(a);
      #0.5;
      v = bus_rdata;
   endtask

   // start, n idle cycles, stop: (n+1) base cycles counted
   task automatic run_window(input int n);
      wr(A_GO, 1);
      idle(n);
      wr(A_HALT, 1);
   endtask

   task automatic setup(input int w, input int p, input int sh, input int m);
      wr(A_WIDTH, w); wr(A_PRESC, p); wr(A_SHORTS, sh); wr(A_MODE, m);
      wr(A_ZERO, 1);
      for (int i = 0; i < NUM_CMP; i++) wr(A_EVT + i, 0);
   endtask

   function automatic logic [31:0] mask_of(input int w);
      case (w)
         1: return 32'hFF;
         2: return 32'hFF_FFFF;
         3: return 32'hFFFF_FFFF;
         default: return 32'hFFFF;
      endcase
   endfunction

   // from a count of 0, after t advances: was value cc ever reached?
   function automatic logic hit_exp(input logic [31:0] cc, input longint t, input logic [31:0] m);
      logic [31:0] c;
      c = cc & m;
      if (t > longint'(m)) return 1'b1;
      return (c != 0) && (longint'(c) <= t);
   endfunction

   logic [31:0] v;

   initial begin
      #(200000 * 5);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      #12 rst_n = 1'b1;
      @(negedge clk); #1;

      // R11: reset state
      rd(A_CNT, v);   chk("R11 count", v, 0);
      rd(A_WIDTH, v); chk("R11 width", v, 0);
      rd(A_CC + 2, v); chk("R11 cc2", v, 0);
      rd(A_PRESC, v); chk("R11 presc", v, 0);
      chk("R11 flags", 32'(cmp_evt), 0);
      idle(5);
      rd(A_CNT, v);   chk("R11 stopped", v, 0);

      // R3: prescaler 2, 40 cycles -> 10 advances
      for (int i = 0; i < NUM_CMP; i++) wr(A_CC + i, 32'h9999);
      setup(0, 2, 0, 0);
      run_window(39);
      rd(A_CNT, v); chk("R3 presc2", v, 10);
      // R1: stopped counter holds; start does not clear
      idle(20);
      rd(A_CNT, v); chk("R1 hold", v, 10);
      wr(A_PRESC, 0);
      run_window(4);
      rd(A_CNT, v); chk("R1 resume", v, 15);
      // R3: clamp
      wr(A_PRESC, 15);
      rd(A_PRESC, v); chk("R3 clamp", v, 9);

      // R5: compare below current count fires only after wrap
      wr(A_CC + 1, 200);
      setup(1, 0, 0, 0);
      run_window(99);
      rd(A_CNT, v); chk("R5 cnt100", v, 100);
      wr(A_CC + 1, 50);
      chk("R5 not yet", 32'(cmp_evt[1]), 0);
      run_window(199);
      rd(A_CNT, v); chk("R4 wrap8", v, 44);
      chk("R5 before reach", 32'(cmp_evt[1]), 0);
      run_window(9);
      chk("R5 after wrap", 32'(cmp_evt[1]), 1);

      // R6: sticky, nonzero write ignored, zero write clears
      wr(A_EVT + 1, 1);
      rd(A_EVT + 1, v); chk("R6 nonzero ignored", v, 1);
      wr(A_EVT + 1, 0);
      chk("R6 cleared", 32'(cmp_evt[1]), 0);

      // R7: shortcut clear on channel 0, period 5
      for (int i = 0; i < NUM_CMP; i++) wr(A_CC + i, 32'hEE);
      wr(A_CC + 0, 5);
      setup(1, 0, 32'h1, 0);
      run_window(22);
      rd(A_CNT, v); chk("R7 period", v, 3);
      chk("R7 flag", 32'(cmp_evt[0]), 1);

      // R8: shortcut stop on channel 1 (bit 5)
      wr(A_CC + 0, 32'hEE);
      wr(A_CC + 1, 7);
      setup(1, 0, 32'h20, 0);
      wr(A_GO, 1);
      idle(30);
      rd(A_CNT, v); chk("R8 stop at cc", v, 7);
      chk("R8 flag", 32'(cmp_evt[1]), 1);
      wr(A_HALT, 1);

      // R9: counter mode
      wr(A_CC + 1, 32'hEE);
      setup(1, 0, 0, 1);
      wr(A_GO, 1);
      idle(50);
      rd(A_CNT, v); chk("R9 no clock count", v, 0);
      for (int k = 0; k < 6; k++) wr(A_BUMP, 1);
      wr(A_HALT, 1);
      rd(A_CNT, v); chk("R9 count", v, 6);
      wr(A_BUMP, 1);
      rd(A_CNT, v); chk("R9 stopped ignores", v, 6);

      // R10 / R2: clear collides with an advance
      setup(1, 0, 0, 0);
      wr(A_GO, 1);
      idle(20);
      wr(A_ZERO, 1);
      rd(A_CNT, v); chk("R10 clear wins", v, 0);
      chk("R2 no flag", 32'(cmp_evt), 0);
      wr(A_HALT, 1);
      rd(A_CNT, v); chk("R2 after clear", v, 1);

      // R4: compare on low bits only
      wr(A_CC + 0, 32'h105);
      setup(1, 0, 0, 0);
      run_window(9);
      chk("R4 low bits", 32'(cmp_evt[0]), 1);

      // R4: 16-bit wrap
      wr(A_CC + 0, 32'hEE);
      wr(A_CC + 2, 3);
      setup(0, 0, 0, 0);
      run_window(65540);
      rd(A_CNT, v); chk("R4 wrap16", v, 5);
      chk("R4 flag16", 32'(cmp_evt[2]), 1);

      // R4: 32-bit
      setup(3, 0, 0, 0);
      run_window(99);
      rd(A_CNT, v); chk("R4 width32", v, 100);

      // random windows: R3 R4 R5
      for (int it = 0; it < 14; it++) begin
         int w, p, n;
         longint t;
         logic [31:0] ccs [NUM_CMP];
         w = (($urandom % 3) == 0) ? int'($urandom % 4) : 1;
         p = $urandom % 4;
         n = $urandom % 700;
         for (int i = 0; i < NUM_CMP; i++) begin
            ccs[i] = $urandom % 512;
            wr(A_CC + i, ccs[i]);
         end
         setup(w, p, 0, 0);
         run_window(n);
         t = longint'((n + 1) >> p);
         rd(A_CNT, v);
         chk($sformatf("R3 rand count w=%0d p=%0d n=%0d", w, p, n), v,
             32'(t & longint'(mask_of(w))));
         for (int i = 0; i < NUM_CMP; i++)
            chk($sformatf("R5 rand flag%0d cc=%0h", i, ccs[i]), 32'(cmp_evt[i]),
                32'(hit_exp(ccs[i], t, mask_of(w))));
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule